// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady periodic event from the system clock. A fixed prescaler divides the clock by 16. Each prescaled tick advances a 20-bit counter, which wraps to zero once it reaches a programmed interval value. Every wrap marks a completed period. A completed period sets a sticky status flag and advances a 12-bit count of finished periods. When interrupts are enabled, it also drives a level interrupt.

Software reads the counter state through two windows. The acknowledging window returns the period count and the live counter, then clears both the flag and the period count. The observing window returns the same fields and changes nothing. Because the two are combined, software can build a monotonic time base: it adds periods times interval to the live counter.

Clearing the run bit does not stop the counter at once. The counter finishes its current period and then parks at zero. Software polls the counter field until it reads zero to confirm the timer has stopped.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While the timer runs, the counter advances by one every 16 clock cycles. The prescaler restarts from zero whenever the timer has been idle, so the first advance after enabling comes 16 cycles after the enabling write.
- R3: A period completes on the tick where the counter is at or above the interval value. The counter then returns to zero, status bit 0 (offset 0x4) is set, and the period count in bits [31:20] of the counter views advances by one. A period therefore lasts interval + 1 ticks.
- R4: The mode register at offset 0x0 holds the interval in bits [19:0], the run enable in bit 24 and the interrupt enable in bit 25. It reads back exactly those bits, and every other bit reads zero.
- R5: A read at offset 0x8 returns {period count[11:0], counter[19:0]}. The same bus cycle clears the status flag and the period count.
- R6: A read at offset 0xC returns the same layout as offset 0x8 and changes no state.
- R7: After the run enable is cleared, the counter keeps counting until it wraps to zero and then holds at zero.
- R8: `irq_o` is high exactly when the status flag and the interrupt enable are both set. It stays high until an acknowledging read. The counter and the period count run whether or not interrupts are enabled.
- R9: The period count wraps from 4095 to 0.
- R10: If a period completes in the same cycle as an acknowledging read, the status flag stays set and the period count becomes 1.
- R11: Writes to any offset other than 0x0 are ignored. Reads of status have no side effects. Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with its default parameters: a prescale of 16, a 20-bit interval and a 12-bit period count. It uses interval values of 0 and 3. An interval of 0 makes every prescaled tick complete a period. This makes an acknowledging read that lands exactly on a completion easy to line up. It also brings the 12-bit wrap of the period count within about 66,000 cycles. An interval of 3 gives a 64-cycle period, which is long enough to catch the counter mid-period, to watch the run-out after disabling, and to see the interrupt held across idle cycles.

// File: rtl/tick_timer_pkg.sv
// Package: shared register offsets and mode-bit positions for the interval timer.
// Assumes byte-addressed 32-bit registers on word-aligned offsets.
package tick_timer_pkg;

    // Register offsets (byte addresses)
    localparam int unsigned OFS_MODE  = 32'h0;
    localparam int unsigned OFS_STAT  = 32'h4;
    localparam int unsigned OFS_VALUE = 32'h8;
    localparam int unsigned OFS_IMAGE = 32'hC;

    // Control bit positions inside the mode register
    localparam int unsigned RUN_BIT = 24;
    localparam int unsigned IEN_BIT = 25;

    // Decoded register selection
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_STAT,
        SEL_VALUE,
        SEL_IMAGE
    } reg_sel_e;

endpackage

// File: rtl/tt_prescaler.sv
// Module: fixed clock divider producing one tick every PRESCALE active cycles.
// Assumes active_i stays low while the timer is idle; the divider is cleared
// then, so counting always restarts from phase zero.
module tt_prescaler #(
    parameter int unsigned PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic tick_o
);

    localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_passthru
            // Every active cycle is a tick when no division is asked for
            assign tick_o = active_i;
        end else begin : g_divider
            localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
            logic [PS_W-1:0] div_q;

            // Divider phase: counts active cycles, cleared while idle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (!active_i) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + PS_W'(1);
                end
            end

            assign tick_o = active_i && (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/tt_interval_core.sv
// Module: interval counter, completed-period count and sticky status flag.
// Assumes tick_i is a single-cycle pulse from the prescaler and ack_i is a
// single-cycle pulse from an acknowledging read.
module tt_interval_core #(
    parameter int unsigned IVAL_W = 20,
    parameter int unsigned PCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en_i,
    input  logic              tick_i,
    input  logic [IVAL_W-1:0] ival_i,
    input  logic              ack_i,
    output logic              active_o,
    output logic              done_o,
    output logic [IVAL_W-1:0] cnt_o,
    output logic [PCNT_W-1:0] pcnt_o,
    output logic              status_o
);

    logic [IVAL_W-1:0] cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              status_q;

    // Keeps running while enabled or until a disabled run drains to zero
    assign active_o = run_en_i || (cnt_q != '0);

    // A period ends on a tick at or beyond the interval (covers shrunk intervals)
    assign done_o = tick_i && (cnt_q >= ival_i);

    // Interval counter: step on each tick, return to zero at period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (done_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + IVAL_W'(1);
            end
        end
    end

    // Completed-period count: wraps, cleared by ack, completion wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (done_o) begin
            if (ack_i) begin
                pcnt_q <= PCNT_W'(1);
            end else begin
                pcnt_q <= pcnt_q + PCNT_W'(1);
            end
        end else if (ack_i) begin
            pcnt_q <= '0;
        end
    end

    // Sticky status flag: set on completion, cleared by ack unless completing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (done_o) begin
            status_q <= 1'b1;
        end else if (ack_i) begin
            status_q <= 1'b0;
        end
    end

    assign cnt_o    = cnt_q;
    assign pcnt_o   = pcnt_q;
    assign status_o = status_q;

endmodule

// File: rtl/tt_bus_regs.sv
// Module: register decode, mode register storage and read-data multiplexer.
// Assumes one-cycle accesses; read data is combinational in the access cycle
// and side effects of a read take place at the closing clock edge.
module tt_bus_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IVAL_W = 20,
    parameter int unsigned PCNT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [IVAL_W+PCNT_W-1:0] bus_wdata,
    output logic [IVAL_W+PCNT_W-1:0] bus_rdata,
    input  logic [IVAL_W-1:0]        cnt_i,
    input  logic [PCNT_W-1:0]        pcnt_i,
    input  logic                     status_i,
    output logic [IVAL_W-1:0]        ival_o,
    output logic                     run_en_o,
    output logic                     irq_en_o,
    output logic                     ack_o
);

    localparam int unsigned DATA_W = IVAL_W + PCNT_W;

    reg_sel_e          sel_w;
    logic [IVAL_W-1:0] ival_q;
    logic              run_en_q;
    logic              irq_en_q;
    logic              mode_wr;
    logic              unused_wbits;

    // Address decode into a register selection
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_MODE)) begin
            sel_w = SEL_MODE;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            sel_w = SEL_STAT;
        end else if (bus_addr == ADDR_W'(OFS_VALUE)) begin
            sel_w = SEL_VALUE;
        end else if (bus_addr == ADDR_W'(OFS_IMAGE)) begin
            sel_w = SEL_IMAGE;
        end else begin
            sel_w = SEL_NONE;
        end
    end

    assign mode_wr = bus_sel && bus_wr && (sel_w == SEL_MODE);
    assign ack_o   = bus_sel && !bus_wr && (sel_w == SEL_VALUE);

    // Mode register: interval and the two enables, written only at its offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q   <= '0;
            run_en_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (mode_wr) begin
            ival_q   <= bus_wdata[IVAL_W-1:0];
            run_en_q <= bus_wdata[RUN_BIT];
            irq_en_q <= bus_wdata[IEN_BIT];
        end
    end

    // Read-data multiplexer: one view per register, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        unique case (sel_w)
            SEL_MODE: begin
                bus_rdata[IVAL_W-1:0] = ival_q;
                bus_rdata[RUN_BIT]    = run_en_q;
                bus_rdata[IEN_BIT]    = irq_en_q;
            end
            SEL_STAT: begin
                bus_rdata[0] = status_i;
            end
            SEL_VALUE, SEL_IMAGE: begin
                bus_rdata = {pcnt_i, cnt_i};
            end
            default: begin
                bus_rdata = '0;
            end
        endcase
    end

    // Write-data bits with no storage behind them
    assign unused_wbits = ^{bus_wdata[DATA_W-1:IEN_BIT+1], bus_wdata[RUN_BIT-1:IVAL_W]};

    assign ival_o   = ival_q;
    assign run_en_o = run_en_q;
    assign irq_en_o = irq_en_q;

endmodule

// File: rtl/tick_interval_timer.sv
// Module: top of the periodic interval timer.
// Wires the bus registers, the prescaler and the interval core together and
// forms the level interrupt. Assumes IVAL_W + PCNT_W equals the bus width and
// IVAL_W stays below the run-enable bit position.
module tick_interval_timer #(
    parameter int unsigned PRESCALE = 16,
    parameter int unsigned IVAL_W   = 20,
    parameter int unsigned PCNT_W   = 12,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [IVAL_W+PCNT_W-1:0] bus_wdata,
    output logic [IVAL_W+PCNT_W-1:0] bus_rdata,
    output logic                     irq_o
);

    logic [IVAL_W-1:0] ival_w;
    logic              run_en_w;
    logic              irq_en_w;
    logic              ack_w;
    logic              active_w;
    logic              tick_w;
    logic              done_w;
    logic [IVAL_W-1:0] cnt_w;
    logic [PCNT_W-1:0] pcnt_w;
    logic              status_w;

    tt_bus_regs #(
        .ADDR_W (ADDR_W),
        .IVAL_W (IVAL_W),
        .PCNT_W (PCNT_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt_w),
        .pcnt_i    (pcnt_w),
        .status_i  (status_w),
        .ival_o    (ival_w),
        .run_en_o  (run_en_w),
        .irq_en_o  (irq_en_w),
        .ack_o     (ack_w)
    );

    tt_prescaler #(
        .PRESCALE (PRESCALE)
    ) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_w),
        .tick_o   (tick_w)
    );

    tt_interval_core #(
        .IVAL_W (IVAL_W),
        .PCNT_W (PCNT_W)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en_i (run_en_w),
        .tick_i   (tick_w),
        .ival_i   (ival_w),
        .ack_i    (ack_w),
        .active_o (active_w),
        .done_o   (done_w),
        .cnt_o    (cnt_w),
        .pcnt_o   (pcnt_w),
        .status_o (status_w)
    );

    // Level interrupt: pending status gated by the interrupt enable
    assign irq_o = status_w && irq_en_w;

endmodule

// File: rtl/tt_timer_checker.sv
// Module: temporal checks on the interval timer, bound into the top module.
// Observes internal nets driven by separate sub-blocks and the bus ports.
module tt_timer_checker
    import tick_timer_pkg::*;
#(
    parameter int unsigned PRESCALE = 16,
    parameter int unsigned IVAL_W   = 20,
    parameter int unsigned PCNT_W   = 12,
    parameter int unsigned ADDR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tick,
    input logic              done,
    input logic              ack,
    input logic              run_en,
    input logic              irq_en,
    input logic [IVAL_W-1:0] cnt,
    input logic [PCNT_W-1:0] pcnt,
    input logic              status,
    input logic              irq
);

    localparam int unsigned GAP_W = $clog2(PRESCALE + 1);

    logic [GAP_W-1:0] since_tick;
    logic             img_rd;

    assign img_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_IMAGE));

    // Cycles since the last tick, saturating at PRESCALE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_tick <= GAP_W'(PRESCALE);
        end else if (tick) begin
            since_tick <= '0;
        end else if (since_tick < GAP_W'(PRESCALE)) begin
            since_tick <= since_tick + GAP_W'(1);
        end
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (since_tick >= GAP_W'(PRESCALE - 1)));

    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> ((cnt == '0) || (cnt == $past(cnt) + IVAL_W'(1))));

    a_r3_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !done) |=> (!status && (pcnt == '0)));

    a_r6_image_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (img_rd && !done) |=> ($stable(status) && $stable(pcnt)));

    a_r7_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && (cnt == '0)) |=> (cnt == '0));

    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(done) || $rose(irq_en)));

    a_r10_tie_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack) |=> (status && (pcnt == PCNT_W'(1))));

endmodule

bind tick_interval_timer tt_timer_checker #(
    .PRESCALE (PRESCALE),
    .IVAL_W   (IVAL_W),
    .PCNT_W   (PCNT_W),
    .ADDR_W   (ADDR_W)
) i_tt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .tick     (tick_w),
    .done     (done_w),
    .ack      (ack_w),
    .run_en   (run_en_w),
    .irq_en   (irq_en_w),
    .cnt      (cnt_w),
    .pcnt     (pcnt_w),
    .status   (status_w),
    .irq      (irq_o)
);

// File: tb/test_tick_interval_timer.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module test_tick_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int PS         = 16;
    localparam int PMOD       = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // Reference model state
    logic [31:0] m_mode;
    int          m_cnt, m_pcnt, m_div, n_since;
    bit          m_stat;
    bit          mv_act, mv_tick, mv_done, mv_ack;

    tick_interval_timer #(.PRESCALE(PS)) i_tick_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: advances on each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 32'h0; m_cnt = 0; m_pcnt = 0; m_div = 0; m_stat = 1'b0; n_since = 0;
        end else begin
            mv_act  = m_mode[24] || (m_cnt != 0);
            mv_tick = mv_act && (m_div == PS - 1);
            m_div   = mv_act ? ((m_div + 1) % PS) : 0;
            mv_done = mv_tick && (m_cnt >= int'(m_mode[19:0]));
            if (mv_tick) m_cnt = mv_done ? 0 : m_cnt + 1;
            mv_ack  = bus_sel && !bus_wr && (bus_addr == 4'h8);
            if (mv_done) begin
                m_stat  = 1'b1;
                m_pcnt  = mv_ack ? 1 : (m_pcnt + 1) % PMOD;
                n_since = mv_ack ? 1 : n_since + 1;
            end else if (mv_ack) begin
                m_stat = 1'b0; m_pcnt = 0; n_since = 0;
            end
            if (bus_sel && bus_wr && (bus_addr == 4'h0)) m_mode = bus_wdata & 32'h030F_FFFF;
        end
    end

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0:       return m_mode;
            4'h4:       return {31'h0, m_stat};
            4'h8, 4'hC: return {m_pcnt[11:0], m_cnt[19:0]};
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0:    return "R4";
            4'h4:    return "R3";
            4'h8:    return "R5";
            4'hC:    return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R8 irq level", {31'h0, irq_o}, {31'h0, (m_stat && m_mode[25])});
            if (bus_sel && !bus_wr) chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        #1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        #1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2; d = bus_rdata;
        @(negedge clk); #1; bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        for (int a = 0; a < 16; a += 4) begin
            bus_read(4'(a), d);
            chk("R1 reset read", d, 32'h0);
        end

        // R2/R4: enable with junk in unused bits, watch tick timing
        bus_write(4'h0, 32'hFDF0_0003);
        idle(8);
        bus_read(4'hC, d); chk("R2 before first tick", d, 32'h0);
        idle(10);
        bus_read(4'hC, d); chk("R2 after first tick", d, 32'h0000_0001);
        idle(16);
        bus_read(4'hC, d); chk("R2 second tick", d, 32'h0000_0002);
        bus_read(4'h0, d); chk("R4 mode readback", d, 32'h0100_0003);

        // R11: writes elsewhere are ignored
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h0, d); chk("R11 mode kept", d, 32'h0100_0003);
        bus_read(4'h4, d); chk("R11 status untouched", d, 32'h0);

        // R3/R6/R8: one completion with interrupts off
        idle(40);
        bus_read(4'h4, d);  chk("R3 status set", d, 32'h1);
        chk("R8 masked irq", {31'h0, irq_o}, 32'h0);
        bus_read(4'hC, d);  chk("R3 period count", {20'h0, d[31:20]}, 32'h1);
        bus_read(4'hC, d2); chk("R6 image repeat", {20'h0, d2[31:20]}, 32'h1);
        bus_read(4'h4, d);  chk("R11 status read twice", d, 32'h1);

        // R5: acknowledging read
        bus_read(4'h8, d);  chk("R5 value count", {20'h0, d[31:20]}, 32'h1);
        bus_read(4'hC, d);  chk("R5 count cleared", {20'h0, d[31:20]}, 32'h0);
        bus_read(4'h4, d);  chk("R5 status cleared", d, 32'h0);

        // R8: interrupt level held until acknowledged
        bus_write(4'h0, 32'h0300_0003);
        idle(70);
        chk("R8 irq raised", {31'h0, irq_o}, 32'h1);
        idle(5);
        chk("R8 irq held", {31'h0, irq_o}, 32'h1);
        bus_read(4'h8, d);
        chk("R8 irq dropped after ack", {31'h0, irq_o}, 32'h0);

        // R7: disable lets the period run out, then parks at zero
        bus_write(4'h0, 32'h0200_0003);
        idle(100);
        bus_read(4'hC, d);  chk("R7 counter parked", {12'h0, d[19:0]}, 32'h0);
        idle(50);
        bus_read(4'hC, d2); chk("R7 still parked", d2, d);

        // R10: completion coinciding with acknowledgement
        bus_write(4'h0, 32'h0100_0000);
        do @(negedge clk); while (!(m_div == PS - 1));
        bus_read(4'h8, d);
        bus_read(4'hC, d);  chk("R10 count is one", d, 32'h0010_0000);
        bus_read(4'h4, d);  chk("R10 status kept", d, 32'h1);

        // R9: period count wraps at 4096
        bus_read(4'h8, d);
        idle(PMOD * PS + 40);
        bus_read(4'hC, d);
        chk("R9 wrapped count", {20'h0, d[31:20]}, 32'(n_since % PMOD));
        chk("R9 wrap reached", {31'h0, (n_since >= PMOD)}, 32'h1);

        idle(4);
        finish_run();
    end

endmodule